// File: doc/BRIEF.md
# Dual-Group Edge Interrupt Controller

This block sits beside a digital I/O device that exposes two 24-line port groups through a 16-byte byte-wide I/O window. In each group, one line can raise an interrupt: bit 3 of that group's third port. The block watches both of these lines and raises one shared, level-type interrupt request when either line shows a rising edge.

Software controls the block through two fixed offsets in the window. A read of offset 0xB turns interrupts off. A write of any value to offset 0xB turns them back on. A write to offset 0xF clears a pending request. All other offsets belong to the neighbouring port logic, and this block ignores them.

Both pin inputs pass through a synchroniser before edge detection. A request stays pending until software clears it. If an edge arrives in the same cycle as a clear, that edge is kept.

Top module: `dual_edge_irq`

## Requirements
- R1: After reset, `irqOut` is low and interrupts are off, so rising edges before the first enable leave `irqOut` low.
- R2: A write of any data value to offset 0xB turns interrupts on.
- R3: With interrupts on, a rising edge on `srcPin[0]` (group 0, third port bit 3) or on `srcPin[1]` (group 1, third port bit 3) sets the pending request. `irqOut` goes high after the third rising clock edge following the pin change and is still low after the second.
- R4: A falling edge, or a pin held steady high, never sets the pending request.
- R5: Edges that arrive while interrupts are off are dropped. Turning interrupts on later leaves `irqOut` low.
- R6: A read of offset 0xB turns interrupts off, and `irqOut` is low from the next clock edge.
- R7: A pending request survives a disable. Re-enabling with a write to 0xB drives `irqOut` high again without a new edge.
- R8: A write to offset 0xF clears the pending request, and `irqOut` is low from the next clock edge.
- R9: A rising edge detected in the same cycle as a clear write leaves the request pending, so `irqOut` stays high.
- R10: Reads and writes to any other offset (for example 0x3, 0x7 and 0xE), and reads of 0xF, change neither the enable state nor the pending request.
- R11: A read and a write to offset 0xB in the same cycle turn interrupts off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Byte offset within the I/O window |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data; its value is ignored |
| srcPin | input | 2 | Monitored lines, index = group |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions assume that each bus strobe lasts exactly one clock cycle. They also assume the pins are low at reset, so the first synchronised sample cannot look like an edge. The bench drives every access for a single cycle between falling clock edges and returns each pin to low before the next scenario. It holds the pins steady for several cycles after every change, so each edge is seen once by the synchroniser. The only exception is the R9 test, which deliberately lines up a clear with the cycle in which an edge is detected.

// File: rtl/dual_edge_irq_pkg.sv
package dual_edge_irq_pkg;
  // Decoded one-cycle strobes from bus decode to the event datapath
  typedef struct packed {
    logic armOn;    // turn interrupts on
    logic armOff;   // turn interrupts off
    logic clrPend;  // drop the pending request
  } irq_strobe_t;
endpackage

// File: rtl/dual_edge_irq_ctrl.sv
module dual_edge_irq_ctrl
  import dual_edge_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OFF_ARM = 4'hB,
  parameter logic [ADDR_W-1:0] OFF_CLR = 4'hF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output irq_strobe_t       strobes
);
  logic hitArm, hitClr;
  logic unusedData;

  assign unusedData = ^busWdata;  // any written value has the same effect
  assign hitArm = (busAddr == OFF_ARM);
  assign hitClr = (busAddr == OFF_CLR);

  always_comb begin
    strobes = '0;
    // a read of the arm offset dominates a simultaneous write (R11)
    strobes.armOff  = hitArm && busRd;
    strobes.armOn   = hitArm && busWr && !busRd;
    strobes.clrPend = hitClr && busWr;
  end

  // R11: on and off never requested together
  p_arm_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.armOn && strobes.armOff));
  // R10: no strobe without an access
  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busRd && !busWr) |-> (strobes == '0));
endmodule

// File: rtl/dual_edge_irq_dp.sv
module dual_edge_irq_dp
  import dual_edge_irq_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  irq_strobe_t        strobes,
  input  logic [NUM_SRC-1:0] srcPin,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] syncLast, syncPrev, riseVec;
  logic riseAny, enabled, pending;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], srcPin[i]};
    end
    assign syncLast[i] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPrev <= '0;
    else       syncPrev <= syncLast;
  end

  assign riseVec = syncLast & ~syncPrev;
  assign riseAny = |riseVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enabled <= 1'b0;
    else if (strobes.armOff)  enabled <= 1'b0;
    else if (strobes.armOn)   enabled <= 1'b1;
  end

  // clear and a fresh edge in the same cycle: the edge wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= (pending && !strobes.clrPend) || (enabled && riseAny);
  end

  assign irqOut = pending && enabled;

  // R6: a disable strobe silences the output on the next edge
  p_off_silences_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.armOff |=> !irqOut);
  // R7: pending survives anything but a clear
  p_pend_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobes.clrPend) |=> pending);
  // R8: clear without a new edge drops the request
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrPend && !riseAny) |=> !pending);
  // R9: an edge coinciding with a clear is kept
  p_edge_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrPend && enabled && riseAny) |=> pending);
  // R5: while off and idle nothing can appear
  p_ignore_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !pending && !strobes.armOn) |=> !irqOut);
endmodule

// File: rtl/dual_edge_irq.sv
module dual_edge_irq
  import dual_edge_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] srcPin,
  output logic               irqOut
);
  irq_strobe_t strobes;

  dual_edge_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .strobes(strobes));

  dual_edge_irq_dp #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcPin(srcPin),
    .irqOut(irqOut));
endmodule

// File: tb/tb_dual_edge_irq.sv
`timescale 1ns/1ps
module tb_dual_edge_irq;
  logic clk = 0, rstN = 0, busRd = 0, busWr = 0;
  logic [3:0] busAddr = 0;
  logic [7:0] busWdata = 0;
  logic [1:0] srcPin = 0;
  logic irqOut;
  int nTests = 0, nFail = 0;

  always #2 clk = ~clk;

  dual_edge_irq dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .srcPin(srcPin), .irqOut(irqOut));

  task automatic check(string req, logic act, logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: irqOut=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle access, effect visible at the returning negedge
  task automatic access(logic [3:0] a, logic rd, logic wr, logic [7:0] d);
    busAddr = a; busRd = rd; busWr = wr; busWdata = d;
    cycles(1);
    busRd = 0; busWr = 0;
  endtask

  task automatic pinsLowSettle();
    srcPin = 0; cycles(4);
  endtask

  task automatic t_reset();
    check("R1 reset", irqOut, 0);
    srcPin[0] = 1; cycles(4);
    check("R1 edge before enable", irqOut, 0);
    pinsLowSettle();
  endtask

  task automatic t_latency(int src);
    access(4'hB, 0, 1, 8'h5A);            // R2 enable
    srcPin[src] = 1;
    cycles(2);
    check("R3 still low after two edges", irqOut, 0);
    cycles(1);
    check("R3 high after third edge", irqOut, 1);
    access(4'hF, 0, 1, 8'h00);
    check("R8 clear", irqOut, 0);
    pinsLowSettle();
    check("R4 falling edge", irqOut, 0);
  endtask

  task automatic t_steady_high();
    srcPin = 2'b11; cycles(4);
    access(4'hF, 0, 1, 0);
    cycles(6);
    check("R4 steady high", irqOut, 0);
    pinsLowSettle();
    check("R4 both fall", irqOut, 0);
  endtask

  task automatic t_ignore_off();
    access(4'hB, 1, 0, 0);                // R6 disable
    srcPin[0] = 1; cycles(4);
    access(4'hB, 0, 1, 8'hFF);
    cycles(2);
    check("R5 edge while off dropped", irqOut, 0);
    pinsLowSettle();
  endtask

  task automatic t_disable_keep();
    srcPin[1] = 1; cycles(3);
    check("R3 source 1", irqOut, 1);
    access(4'hB, 1, 0, 0);
    check("R6 read disables", irqOut, 0);
    access(4'hB, 0, 1, 8'h00);
    check("R7 pending survives", irqOut, 1);
    access(4'hF, 0, 1, 0);
    pinsLowSettle();
  endtask

  task automatic t_other_offsets();
    srcPin[0] = 1; cycles(3);
    check("R10 setup pending", irqOut, 1);
    access(4'h3, 1, 1, 8'h80);
    access(4'h7, 0, 1, 8'h00);
    access(4'hE, 1, 0, 0);
    access(4'hF, 1, 0, 0);
    check("R10 other offsets ignored", irqOut, 1);
    access(4'hF, 0, 1, 0);
    access(4'hE, 0, 1, 0);
    access(4'h0, 1, 0, 0);
    check("R10 state after other offsets", irqOut, 0);
    pinsLowSettle();
  endtask

  task automatic t_clear_collide();
    srcPin[0] = 1; cycles(3);
    check("R9 setup", irqOut, 1);
    srcPin[1] = 1;
    cycles(2);                             // edge detected in the coming cycle
    access(4'hF, 0, 1, 0);
    check("R9 edge kept over clear", irqOut, 1);
    access(4'hF, 0, 1, 0);
    check("R8 clear after collision", irqOut, 0);
    pinsLowSettle();
  endtask

  task automatic t_both_strobes();
    srcPin[0] = 1; cycles(3);
    access(4'hB, 1, 1, 8'h11);
    check("R11 read wins", irqOut, 0);
    access(4'hF, 0, 1, 0);
    pinsLowSettle();
    access(4'hB, 0, 1, 0);
    check("R2 re-enable with nothing pending", irqOut, 0);
  endtask

  initial begin
    cycles(3);
    rstN = 1;
    cycles(1);
    t_reset();
    t_latency(0);
    t_latency(1);
    t_steady_high();
    t_ignore_off();
    access(4'hB, 0, 1, 0);
    t_disable_keep();
    t_other_offsets();
    t_clear_collide();
    t_both_strobes();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: done=0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule